// File: doc/BRIEF.md
# Configuration Bitstream Sync Locator

This block sits on the byte stream of a configuration image and finds where the configuration payload begins. A start pulse arms it for one image and captures the image size and the search mode. In raw mode it first steps over a fixed preamble and a chain of length-prefixed information records. It then looks for a run of all-ones bytes that opens the payload. In compressed mode it ignores the header and scans the image from its first byte for a two-byte marker: an all-ones byte followed by a byte whose high nibble is 3.

Bytes ahead of the payload are consumed and thrown away. When the marker is seen, the block records the byte offset where the payload starts and the number of payload bytes left, raises a found flag, and passes the payload downstream with valid/ready flow control. If the image ends with no marker, the block raises a missing flag and forwards nothing. Neither the record text nor the payload content is interpreted.

Top module: `bitstream_sync_locator`

## Requirements
- R1: After reset, and until the first start pulse, in_ready, out_valid, sync_found and sync_missing are all 0.
- R2: In raw mode the record walk begins at byte offset 15. Four records are skipped: at each step the byte at the current pointer is the record length L, and the pointer moves forward by L + 3. Bytes before the final pointer never count toward the sync run, even if they are 0xFF, and a pointer that moves past the image end gives sync_missing.
- R3: In raw mode the payload starts at the first offset, at or after the final record pointer, that opens four consecutive 0xFF bytes. start_offset equals that offset, and the four 0xFF bytes are the first four bytes forwarded.
- R4: In compressed mode the search starts at offset 0 and matches at the first offset k where byte k is 0xFF and (byte k+1 AND 0xF0) is 0x30. start_offset is k+2, and neither marker byte is forwarded.
- R5: Once sync_found is 1, payload_len equals image_size minus start_offset. Zero is a valid length.
- R6: Every byte from start_offset to image_size-1 appears on the output once, in order, and no other byte does. A stalled out_ready holds out_valid and out_data.
- R7: If the last image byte is consumed with no match, sync_missing goes to 1 and no byte is forwarded. A final 0xFF byte with nothing after it is not a compressed match.
- R8: A start pulse clears sync_found and sync_missing and restarts the search for a new image in the selected mode, including when it arrives partway through an image.
- R9: After the last image byte (or once sync_missing is set), in_ready and out_valid stay 0 until the next start pulse, whatever in_valid does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that arms the search for a new image |
| mode_cmp | input | 1 | Mode captured at start: 0 raw, 1 compressed |
| image_size | input | IDX_W | Total image size in bytes (at least 2), captured at start |
| in_data | input | 8 | Incoming image byte |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Block accepts in_data this cycle |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | out_data is valid |
| out_ready | input | 1 | Downstream accepts out_data |
| sync_found | output | 1 | Marker located; offset and length are valid |
| sync_missing | output | 1 | Image ended with no marker |
| start_offset | output | IDX_W | Byte offset of the first payload byte |
| payload_len | output | IDX_W | Number of payload bytes |

## Verification
Raw images sweep the four record lengths against the position of the all-ones run. Decoys include 0xFF runs inside record bodies, runs that straddle the end of the header, a three-byte partial run just before the real one, and a five-byte run. Together these separate a correct pointer walk and first-run detection from walks that are off by one or that count header bytes. Compressed images move the marker across every legal position of a small image, down to a zero-length payload. They place lookalike pairs before it (0xFF then 0x2X or 0x4X, and doubled 0xFF) and a second valid marker after it, which tests the nibble mask and first-match priority. Images with no marker, an aborted image, and random stalls on both sides cover the miss flag, rearming and flow control.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR  = 3'd1,
        ST_RAW  = 3'd2,
        ST_CMP  = 3'd3,
        ST_EMIT = 3'd4,
        ST_PASS = 3'd5,
        ST_DONE = 3'd6
    } bsl_state_e;

    localparam logic [7:0] SYNC_BYTE = 8'hFF;
    localparam logic [7:0] CMP_MASK  = 8'hF0;
    localparam logic [7:0] CMP_PAT   = 8'h30;

endpackage

// File: rtl/bsl_hdr_walker.sv
module bsl_hdr_walker #(
    parameter int IDX_W    = 16,
    parameter int HDR_BASE = 15,
    parameter int NUM_REC  = 4,
    parameter int REC_PAD  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             take,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       data,
    output logic             hunt_now,
    output logic             walked
);
    localparam int CW = $clog2(NUM_REC + 1);
    localparam logic [IDX_W-1:0] BASE_V = IDX_W'(HDR_BASE);
    localparam logic [IDX_W-1:0] PAD_V  = IDX_W'(REC_PAD);
    localparam logic [CW-1:0]    REC_MAX = CW'(NUM_REC);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
        logic [CW-1:0]    rec;
    } walk_t;

    walk_t walk_d, walk_q;
    logic  at_ptr;

    always_comb begin
        walk_d   = walk_q;
        at_ptr   = (idx == walk_q.ptr);
        walked   = (walk_q.rec == REC_MAX);
        hunt_now = walked && at_ptr;
        if (clear) begin
            walk_d.ptr = BASE_V;
            walk_d.rec = '0;
        end else if (take && at_ptr && !walked) begin
            walk_d.ptr = idx + {{(IDX_W-8){1'b0}}, data} + PAD_V;
            walk_d.rec = walk_q.rec + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            walk_q.ptr <= BASE_V;
            walk_q.rec <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    // R2
    rec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (walk_q.rec != $past(walk_q.rec)) |->
            ((walk_q.rec == $past(walk_q.rec) + 1'b1) || (walk_q.rec == '0)));

    // R2
    rec_bound_chk: assert property (@(posedge clk) disable iff (rst)
        walk_q.rec <= REC_MAX);

endmodule

// File: rtl/bsl_run_detect.sv
module bsl_run_detect #(
    parameter int RUN_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       take,
    input  logic [7:0] data,
    output logic       hit
);
    import bsl_pkg::*;

    localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] TOP = CW'(RUN_LEN - 1);

    logic [CW-1:0] run_d, run_q;
    logic          is_sync;

    always_comb begin
        run_d   = run_q;
        is_sync = (data == SYNC_BYTE);
        hit     = take && is_sync && (run_q == TOP);
        if (clear) begin
            run_d = '0;
        end else if (take) begin
            if (!is_sync) begin
                run_d = '0;
            end else if (run_q != TOP) begin
                run_d = run_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    // R3
    run_break_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !clear && data != SYNC_BYTE) |=> (run_q == '0));

endmodule

// File: rtl/bsl_nibble_detect.sv
module bsl_nibble_detect (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       take,
    input  logic [7:0] data,
    output logic       hit
);
    import bsl_pkg::*;

    logic prev_ff_d, prev_ff_q;

    always_comb begin
        prev_ff_d = prev_ff_q;
        hit       = take && prev_ff_q && ((data & CMP_MASK) == CMP_PAT);
        if (clear) begin
            prev_ff_d = 1'b0;
        end else if (take) begin
            prev_ff_d = (data == SYNC_BYTE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ff_q <= 1'b0;
        end else begin
            prev_ff_q <= prev_ff_d;
        end
    end

    // R4
    prev_track_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !clear) |=> (prev_ff_q == ($past(data) == SYNC_BYTE)));

endmodule

// File: rtl/bitstream_sync_locator.sv
module bitstream_sync_locator #(
    parameter int IDX_W    = 16,
    parameter int HDR_BASE = 15,
    parameter int NUM_REC  = 4,
    parameter int REC_PAD  = 3,
    parameter int RUN_LEN  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode_cmp,
    input  logic [IDX_W-1:0] image_size,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_valid,
    output logic             sync_found,
    output logic             sync_missing,
    output logic [IDX_W-1:0] start_offset,
    output logic [IDX_W-1:0] payload_len
);
    import bsl_pkg::*;

    localparam int EW = $clog2(RUN_LEN + 1);
    localparam logic [IDX_W-1:0] BACK  = IDX_W'(RUN_LEN - 1);
    localparam logic [IDX_W-1:0] ONE   = IDX_W'(1);
    localparam logic [EW-1:0]    EMITN = EW'(RUN_LEN);
    localparam logic [EW-1:0]    EMIT1 = EW'(1);

    typedef struct packed {
        bsl_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] size;
        logic             found;
        logic             miss;
        logic [IDX_W-1:0] soff;
        logic [IDX_W-1:0] plen;
        logic [EW-1:0]    emit;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic acc;
    logic last_byte;
    logic hdr_take;
    logic raw_take;
    logic cmp_take;
    logic hunt_now;
    logic walked;
    logic raw_hit;
    logic cmp_hit;

    // Handshake and data path
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = in_data;
        unique case (ctl_q.st)
            ST_HDR, ST_RAW, ST_CMP: in_ready = 1'b1;
            ST_EMIT: begin
                out_valid = 1'b1;
                out_data  = SYNC_BYTE;
            end
            ST_PASS: begin
                in_ready  = out_ready;
                out_valid = in_valid;
            end
            default: ;
        endcase
        if (start) begin
            in_ready  = 1'b0;
            out_valid = 1'b0;
        end
    end

    always_comb begin
        acc       = in_valid && in_ready;
        last_byte = (ctl_q.idx == ctl_q.size - ONE);
        hdr_take  = acc && (ctl_q.st == ST_HDR);
        raw_take  = acc && ((ctl_q.st == ST_RAW) || ((ctl_q.st == ST_HDR) && hunt_now));
        cmp_take  = acc && (ctl_q.st == ST_CMP);
    end

    bsl_hdr_walker #(
        .IDX_W    (IDX_W),
        .HDR_BASE (HDR_BASE),
        .NUM_REC  (NUM_REC),
        .REC_PAD  (REC_PAD)
    ) u_walk (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .take     (hdr_take),
        .idx      (ctl_q.idx),
        .data     (in_data),
        .hunt_now (hunt_now),
        .walked   (walked)
    );

    bsl_run_detect #(
        .RUN_LEN (RUN_LEN)
    ) u_run (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .take  (raw_take),
        .data  (in_data),
        .hit   (raw_hit)
    );

    bsl_nibble_detect u_nib (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .take  (cmp_take),
        .data  (in_data),
        .hit   (cmp_hit)
    );

    // Next-state computation
    always_comb begin
        ctl_d = ctl_q;
        if (acc) begin
            ctl_d.idx = ctl_q.idx + ONE;
        end
        unique case (ctl_q.st)
            ST_HDR, ST_RAW: begin
                if (raw_hit) begin
                    ctl_d.found = 1'b1;
                    ctl_d.soff  = ctl_q.idx - BACK;
                    ctl_d.plen  = ctl_q.size - (ctl_q.idx - BACK);
                    ctl_d.emit  = EMITN;
                    ctl_d.st    = ST_EMIT;
                end else if (acc && last_byte) begin
                    ctl_d.miss = 1'b1;
                    ctl_d.st   = ST_DONE;
                end else if (raw_take) begin
                    ctl_d.st = ST_RAW;
                end
            end
            ST_CMP: begin
                if (cmp_hit) begin
                    ctl_d.found = 1'b1;
                    ctl_d.soff  = ctl_q.idx + ONE;
                    ctl_d.plen  = ctl_q.size - ctl_q.idx - ONE;
                    ctl_d.st    = last_byte ? ST_DONE : ST_PASS;
                end else if (acc && last_byte) begin
                    ctl_d.miss = 1'b1;
                    ctl_d.st   = ST_DONE;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    ctl_d.emit = ctl_q.emit - EMIT1;
                    if (ctl_q.emit == EMIT1) begin
                        ctl_d.st = (ctl_q.idx == ctl_q.size) ? ST_DONE : ST_PASS;
                    end
                end
            end
            ST_PASS: begin
                if (acc && last_byte) begin
                    ctl_d.st = ST_DONE;
                end
            end
            default: ;
        endcase
        if (start) begin
            ctl_d.st    = mode_cmp ? ST_CMP : ST_HDR;
            ctl_d.idx   = '0;
            ctl_d.size  = image_size;
            ctl_d.found = 1'b0;
            ctl_d.miss  = 1'b0;
            ctl_d.soff  = '0;
            ctl_d.plen  = '0;
            ctl_d.emit  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.idx   <= '0;
            ctl_q.size  <= '0;
            ctl_q.found <= 1'b0;
            ctl_q.miss  <= 1'b0;
            ctl_q.soff  <= '0;
            ctl_q.plen  <= '0;
            ctl_q.emit  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sync_found   = ctl_q.found;
    assign sync_missing = ctl_q.miss;
    assign start_offset = ctl_q.soff;
    assign payload_len  = ctl_q.plen;

    // R5
    found_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sync_found && sync_missing));

    // R6
    out_needs_found_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> sync_found);

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst || start)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R3
    found_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_found) |-> $past(in_valid && in_ready));

    // R7
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sync_missing |-> (!out_valid && !in_ready));

endmodule

// File: tb/bitstream_sync_locator_bench.sv
`timescale 1ns/1ps
module bitstream_sync_locator_bench;

    localparam int IW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          mode_cmp;
    logic [IW-1:0] image_size;
    logic [7:0]    in_data;
    logic          in_valid;
    logic          in_ready;
    logic          out_ready;
    logic [7:0]    out_data;
    logic          out_valid;
    logic          sync_found;
    logic          sync_missing;
    logic [IW-1:0] start_offset;
    logic [IW-1:0] payload_len;

    always #10 clk = ~clk;

    bitstream_sync_locator u_bitstream_sync_locator (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .mode_cmp     (mode_cmp),
        .image_size   (image_size),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .out_valid    (out_valid),
        .sync_found   (sync_found),
        .sync_missing (sync_missing),
        .start_offset (start_offset),
        .payload_len  (payload_len)
    );

    int vec_cnt = 0;
    int bad_cnt = 0;

    logic [7:0]  img [0:127];
    logic [7:0]  got [0:127];
    int          img_size;
    int          got_n;
    bit          exp_found;
    int          exp_start;
    logic [15:0] lf = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vec_cnt++;
        if (!ok) begin
            bad_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step_lf();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    // Reference search computed from the requirements
    function automatic void model(input bit cmp);
        int p;
        int run;
        exp_found = 1'b0;
        exp_start = 0;
        if (cmp) begin
            for (int i = 0; i < img_size - 1; i++) begin
                if (img[i] == 8'hFF && (img[i+1] & 8'hF0) == 8'h30) begin
                    exp_found = 1'b1;
                    exp_start = i + 2;
                    return;
                end
            end
        end else begin
            p = 15;
            for (int r = 0; r < 4; r++) begin
                if (p >= img_size) return;
                p = p + int'(img[p]) + 3;
            end
            run = 0;
            for (int i = p; i < img_size; i++) begin
                run = (img[i] == 8'hFF) ? run + 1 : 0;
                if (run == 4) begin
                    exp_found = 1'b1;
                    exp_start = i - 3;
                    return;
                end
            end
        end
    endfunction

    task automatic fill(input int size);
        img_size = size;
        for (int i = 0; i < 128; i++) begin
            step_lf();
            img[i] = lf[7:0] & 8'hFE;
        end
    endtask

    task automatic put_hdr(input int l0, input int l1, input int l2, input int l3, output int p);
        int lens [4];
        lens = '{l0, l1, l2, l3};
        p = 15;
        for (int r = 0; r < 4; r++) begin
            img[p] = 8'(lens[r]);
            p = p + lens[r] + 3;
        end
    endtask

    task automatic run_image(input bit cmp, input bit stall, input int abort_after);
        int    ptr;
        int    cyc;
        int    exp_len;
        bit    fire;
        bit    done;
        string rq;
        model(cmp);
        rq = cmp ? "R4" : "R3";
        exp_len = exp_found ? img_size - exp_start : 0;
        @(negedge clk);
        start      = 1'b1;
        mode_cmp   = cmp;
        image_size = IW'(img_size);
        in_valid   = 1'b0;
        out_ready  = 1'b0;
        @(negedge clk);
        start = 1'b0;
        #1;
        if (abort_after == 0)
            chk(!sync_found && !sync_missing, "R8 flags cleared by start",
                int'({sync_found, sync_missing}), 0);
        ptr = 0; cyc = 0; fire = 1'b0; done = 1'b0; got_n = 0;
        while (!done && cyc < 4000) begin
            if (fire) ptr++;
            if (!in_valid || fire)
                in_valid = (ptr < img_size) && (!stall || lf[0] || lf[3]);
            in_data   = (ptr < img_size) ? img[ptr] : 8'h00;
            out_ready = !stall || lf[5] || lf[9];
            step_lf();
            #1;
            fire = in_valid && in_ready;
            if (out_valid && out_ready && got_n < 128) begin
                got[got_n] = out_data;
                got_n++;
            end
            cyc++;
            if (abort_after > 0 && cyc >= abort_after) return;
            if (sync_missing || (sync_found && got_n >= exp_len)) done = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        #1;
        chk(done, "R6 image completes", int'(done), 1);
        chk(sync_found == exp_found, {rq, " found flag"}, int'(sync_found), int'(exp_found));
        chk(sync_missing == !exp_found, "R7 missing flag", int'(sync_missing), int'(!exp_found));
        if (exp_found) begin
            chk(int'(start_offset) == exp_start, {rq, " start offset"}, int'(start_offset), exp_start);
            chk(int'(payload_len) == exp_len, "R5 payload length", int'(payload_len), exp_len);
            chk(got_n == exp_len, "R6 forwarded byte count", got_n, exp_len);
            for (int i = 0; i < exp_len && i < got_n; i++)
                chk(got[i] == img[exp_start + i], (i < 4) ? {rq, " leading payload byte"} : "R6 payload byte",
                    int'(got[i]), int'(img[exp_start + i]));
        end else begin
            chk(got_n == 0, "R7 nothing forwarded", got_n, 0);
        end
        in_valid  = 1'b1;
        in_data   = 8'h5A;
        out_ready = 1'b1;
        #1;
        chk(!in_ready && !out_valid, "R9 quiet after image end", int'({in_ready, out_valid}), 0);
        @(negedge clk);
        #1;
        chk(!in_ready && !out_valid, "R9 quiet one cycle later", int'({in_ready, out_valid}), 0);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad_cnt++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin
        int p;
        rst = 1'b1; start = 1'b0; mode_cmp = 1'b0; image_size = '0;
        in_data = '0; in_valid = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(!in_ready && !out_valid && !sync_found && !sync_missing, "R1 reset state",
            int'({in_ready, out_valid, sync_found, sync_missing}), 0);
        rst = 1'b0;
        in_valid = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);
        #1;
        chk(!in_ready && !out_valid && !sync_found && !sync_missing, "R1 idle before start",
            int'({in_ready, out_valid, sync_found, sync_missing}), 0);
        in_valid = 1'b0;

        // Raw sweep: record lengths against run position, with decoys (R2, R3)
        for (int a = 0; a < 5; a++) begin
            for (int q = 0; q < 5; q++) begin
                fill(64);
                put_hdr(a, 4 - a, 2, a % 2, p);
                if (a == 4) for (int j = 16; j < 20; j++) img[j] = 8'hFF;
                if (q == 4) begin
                    img[p] = 8'hFF; img[p+1] = 8'hFF; img[p+2] = 8'hFF;
                end
                for (int j = 0; j < 4; j++) img[p+q+j] = 8'hFF;
                if (q == 2) img[p+q+4] = 8'hFF;
                run_image(1'b0, ((a + q) % 2) == 1, 0);
            end
        end

        // R2: run straddling the hunt point must not match there
        fill(50);
        put_hdr(2, 2, 2, 2, p);
        img[p-2] = 8'hFF; img[p-1] = 8'hFF; img[p] = 8'hFF; img[p+1] = 8'hFF;
        for (int j = 40; j < 44; j++) img[j] = 8'hFF;
        run_image(1'b0, 1'b1, 0);

        // R7: raw with only partial runs
        fill(40);
        put_hdr(1, 1, 1, 1, p);
        img[16] = 8'hFF; img[17] = 8'hFF;
        img[33] = 8'hFF; img[34] = 8'hFF; img[35] = 8'hFF;
        img[37] = 8'hFF; img[38] = 8'hFF; img[39] = 8'hFF;
        run_image(1'b0, 1'b0, 0);

        // R2, R7: record pointer jumps past the image end
        fill(30);
        img[15] = 8'd200;
        for (int j = 20; j < 24; j++) img[j] = 8'hFF;
        run_image(1'b0, 1'b0, 0);

        // Compressed sweep over every marker position (R4, R5)
        for (int k = 0; k < 23; k++) begin
            fill(24);
            if (k >= 1) img[k-1] = (k % 2 == 1) ? 8'hFF : 8'h4F;
            if (k >= 2) img[k-2] = 8'hFF;
            img[k]   = 8'hFF;
            img[k+1] = 8'h30 | 8'(k & 15);
            if (k + 4 < 24) begin
                img[k+3] = 8'hFF; img[k+4] = 8'h35;
            end
            run_image(1'b1, (k % 2) == 1, 0);
        end

        // R7: compressed with lookalikes and a trailing 0xFF
        fill(20);
        img[5] = 8'hFF; img[6] = 8'h2C;
        img[10] = 8'hFF; img[11] = 8'h40;
        img[19] = 8'hFF;
        run_image(1'b1, 1'b1, 0);

        // R8: abort a raw image midway, then run a compressed image
        fill(64);
        put_hdr(1, 2, 3, 0, p);
        for (int j = 0; j < 4; j++) img[p+2+j] = 8'hFF;
        run_image(1'b0, 1'b0, 12);
        fill(30);
        img[7] = 8'hFF; img[8] = 8'h3E;
        run_image(1'b1, 1'b0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

endmodule